// File: doc/BRIEF.md
# Configuration ROM CRC-16 Folder

This block produces the 16-bit check word that guards a block of 32-bit quadlets, for example a bus topology table or a speed table that is published through a configuration space. A caller pulses a start strobe, then streams the quadlets that the check must cover over a valid/ready handshake. The header quadlet, which later holds the result, is never streamed. When the final quadlet has been absorbed, the block raises a one-cycle done strobe with the check word on its output.

The check runs on 4-bit digits, not single bits. Each quadlet is broken into eight digits and the most significant digit is taken first. For every digit the top nibble of the running value is XORed with the digit, and the resulting feedback nibble is folded back in at bit offsets 12, 5 and 0 while the running value moves up four places. By default one digit is folded per clock, so a quadlet occupies eight cycles, and the input is stalled during that time. A build parameter selects how the final quadlet is recognised. In one mode a quadlet count is supplied with the start strobe. In the other mode the caller marks the final quadlet with a flag.

Top module: `cfgrom_crc16`

## Requirements
- R1: The result equals the digit fold of the covered quadlets in stream order. Each quadlet is split into eight 4-bit digits, taken from bits 31:28 down to bits 3:0. For each digit, fb = value[15:12] XOR digit, and then value = ((value << 4) XOR (fb << 12) XOR (fb << 5) XOR fb), truncated to 16 bits. The value carries over from one quadlet into the next.
- R2: After reset, crc_o is 0, done_o is 0, busy_o is 0 and in_ready_o is 0.
- R3: A start_i pulse sets crc_o to 0 on the following cycle and raises in_ready_o, except for a zero-count request in count mode. A start that arrives in the middle of a run abandons that run.
- R4: After each accepted quadlet (in_valid_i and in_ready_o both high at a clock edge), in_ready_o stays low for the eight folding cycles.
- R5: done_o is high for exactly one cycle. It rises eight cycles after the clock edge that accepts the final quadlet. crc_o holds its value from that point until the next start.
- R6: In count mode (USE_COUNT=1), the result covers exactly count_i quadlets, counted from the start pulse, and in_last_i is ignored.
- R7: In flag mode (USE_COUNT=0), the run ends with the quadlet that was accepted with in_last_i high, and count_i is ignored.
- R8: In count mode, a start with count_i = 0 raises done_o on the next cycle with crc_o = 0, and no quadlet is requested.
- R9: While the block is not busy, in_ready_o is low and in_valid_i has no effect: crc_o and done_o stay unchanged.
- R10: A single quadlet 32'h00000001 gives the result 16'h1021, and a single all-zero quadlet gives 16'h0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe: clears the check and opens a run |
| count_i | input | CNT_W | Number of quadlets to cover (count mode only) |
| in_valid_i | input | 1 | Quadlet offered |
| in_ready_o | output | 1 | Block accepts a quadlet this cycle |
| in_data_i | input | DATA_W | Quadlet value |
| in_last_i | input | 1 | Offered quadlet is the final one (flag mode only) |
| busy_o | output | 1 | A run is open |
| done_o | output | 1 | One-cycle strobe: result is ready |
| crc_o | output | 16 | Running value, which is the final result once done_o has risen |

## Verification
A fault in the digit-fold data path, such as a wrong feedback tap, the wrong digit order, or a lost carry between quadlets, shows up only as a wrong crc_o. It becomes visible in the same cycle that done_o rises, eight cycles after the final handshake, so runs of different lengths and offsets are each compared against an independent model. A fault in the step counter or the sequencer shows up at the handshake instead: in_ready_o comes back too early or too late, or done_o fires after the wrong quadlet. The bench therefore samples in_ready_o and done_o on exact cycles around every quadlet. Mode faults, such as a count-mode run that obeys in_last_i, appear as a done strobe after the first quadlet. They are exposed by driving both modes with the same stream and a deliberately early last flag.

// File: rtl/crc16_pkg.sv
package crc16_pkg;

   localparam int CRC_W   = 16;
   localparam int DIGIT_W = 4;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_ACCEPT = 2'd1,
      ST_FOLD   = 2'd2
   } crc_state_t;

   // Fold one 4-bit digit into the running 16-bit value.
   function automatic logic [CRC_W-1:0] fold_digit(input logic [CRC_W-1:0] cur,
                                                   input logic [DIGIT_W-1:0] dig);
      logic [DIGIT_W-1:0] fb;
      fb = cur[CRC_W-1 -: DIGIT_W] ^ dig;
      return {cur[CRC_W-DIGIT_W-1:0], {DIGIT_W{1'b0}}}
           ^ {fb, 12'd0}
           ^ {7'd0, fb, 5'd0}
           ^ {12'd0, fb};
   endfunction

endpackage

// File: rtl/crc16_step_unit.sv
module crc16_step_unit
   import crc16_pkg::*;
#(
   parameter int DPC = 1
) (
   input  logic [CRC_W-1:0]       crc_i,
   input  logic [DPC*DIGIT_W-1:0] dig_i,
   output logic [CRC_W-1:0]       crc_o
);

   localparam int CHUNK = DPC * DIGIT_W;

   logic [CRC_W-1:0] stage [DPC+1];

   assign stage[0] = crc_i;

   for (genvar i = 0; i < DPC; i++) begin : g_digit
      assign stage[i+1] = fold_digit(stage[i], dig_i[CHUNK-1-DIGIT_W*i -: DIGIT_W]);
   end

   assign crc_o = stage[DPC];

endmodule

// File: rtl/crc16_quad_shifter.sv
module crc16_quad_shifter #(
   parameter int DATA_W = 32,
   parameter int CHUNK  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic              shift_i,
   input  logic [DATA_W-1:0] data_i,
   output logic [CHUNK-1:0]  chunk_o
);

   logic [DATA_W-1:0] hold_q;

   if (DATA_W > CHUNK) begin : g_shift
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            hold_q <= '0;
         else if (load_i)
            hold_q <= data_i;
         else if (shift_i)
            hold_q <= {hold_q[DATA_W-CHUNK-1:0], {CHUNK{1'b0}}};
      end
   end else begin : g_whole
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            hold_q <= '0;
         else if (load_i)
            hold_q <= data_i;
      end
   end

   assign chunk_o = hold_q[DATA_W-1 -: CHUNK];

endmodule

// File: rtl/crc16_seq_ctrl.sv
module crc16_seq_ctrl
   import crc16_pkg::*;
#(
   parameter int STEPS     = 8,
   parameter int CNT_W     = 16,
   parameter bit USE_COUNT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [CNT_W-1:0] count_i,
   input  logic             valid_i,
   input  logic             last_i,
   output logic             ready_o,
   output logic             busy_o,
   output logic             load_o,
   output logic             fold_o,
   output logic             done_o
);

   localparam int SC_W = (STEPS > 1) ? $clog2(STEPS) : 1;
   localparam logic [SC_W-1:0] STEP_LAST = SC_W'(STEPS - 1);

   crc_state_t      state_q;
   logic [SC_W-1:0] step_q;
   logic            final_q;
   logic            done_q;
   logic            hs;
   logic            is_final;
   logic            zero_req;

   assign hs = (state_q == ST_ACCEPT) && valid_i && !start_i;

   if (USE_COUNT) begin : g_count
      logic [CNT_W-1:0] left_q;
      logic             unused_last;

      assign unused_last = last_i;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            left_q <= '0;
         else if (start_i)
            left_q <= count_i;
         else if (hs)
            left_q <= left_q - 1'b1;
      end

      assign is_final = (left_q == CNT_W'(1));
      assign zero_req = (count_i == '0);
   end else begin : g_flag
      logic unused_cnt;

      assign unused_cnt = ^count_i;
      assign is_final   = last_i;
      assign zero_req   = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         step_q  <= '0;
         final_q <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (start_i) begin
            step_q  <= '0;
            final_q <= 1'b0;
            done_q  <= zero_req;
            state_q <= zero_req ? ST_IDLE : ST_ACCEPT;
         end else begin
            case (state_q)
               ST_ACCEPT: begin
                  if (valid_i) begin
                     state_q <= ST_FOLD;
                     step_q  <= '0;
                     final_q <= is_final;
                  end
               end
               ST_FOLD: begin
                  if (step_q == STEP_LAST) begin
                     step_q <= '0;
                     if (final_q) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                     end else begin
                        state_q <= ST_ACCEPT;
                     end
                  end else begin
                     step_q <= step_q + 1'b1;
                  end
               end
               default: state_q <= ST_IDLE;
            endcase
         end
      end
   end

   assign ready_o = (state_q == ST_ACCEPT);
   assign busy_o  = (state_q != ST_IDLE);
   assign load_o  = hs;
   assign fold_o  = (state_q == ST_FOLD) && !start_i;
   assign done_o  = done_q;

endmodule

// File: rtl/cfgrom_crc16.sv
module cfgrom_crc16
   import crc16_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int DPC       = 1,
   parameter int CNT_W     = 16,
   parameter bit USE_COUNT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [CNT_W-1:0]  count_i,
   input  logic              in_valid_i,
   output logic              in_ready_o,
   input  logic [DATA_W-1:0] in_data_i,
   input  logic              in_last_i,
   output logic              busy_o,
   output logic              done_o,
   output logic [CRC_W-1:0]  crc_o
);

   localparam int CHUNK = DPC * DIGIT_W;
   localparam int STEPS = DATA_W / CHUNK;

   if (DPC < 1) begin : g_bad_dpc
      $error("cfgrom_crc16: DPC must be at least 1");
   end
   if ((DATA_W % CHUNK) != 0) begin : g_bad_width
      $error("cfgrom_crc16: DATA_W must be a multiple of 4*DPC");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("cfgrom_crc16: CNT_W must be at least 1");
   end

   logic             load;
   logic             fold;
   logic [CHUNK-1:0] chunk;
   logic [CRC_W-1:0] crc_q;
   logic [CRC_W-1:0] crc_next;

   crc16_seq_ctrl #(
      .STEPS     (STEPS),
      .CNT_W     (CNT_W),
      .USE_COUNT (USE_COUNT)
   ) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start_i),
      .count_i (count_i),
      .valid_i (in_valid_i),
      .last_i  (in_last_i),
      .ready_o (in_ready_o),
      .busy_o  (busy_o),
      .load_o  (load),
      .fold_o  (fold),
      .done_o  (done_o)
   );

   crc16_quad_shifter #(
      .DATA_W (DATA_W),
      .CHUNK  (CHUNK)
   ) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (load),
      .shift_i (fold),
      .data_i  (in_data_i),
      .chunk_o (chunk)
   );

   crc16_step_unit #(
      .DPC (DPC)
   ) u_step (
      .crc_i (crc_q),
      .dig_i (chunk),
      .crc_o (crc_next)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         crc_q <= '0;
      else if (start_i)
         crc_q <= '0;
      else if (fold)
         crc_q <= crc_next;
   end

   assign crc_o = crc_q;

endmodule

// File: rtl/crc16_chk.sv
module crc16_chk #(
   parameter int CNT_W     = 16,
   parameter bit USE_COUNT = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic [CNT_W-1:0] count_i,
   input logic             in_valid_i,
   input logic             in_ready_o,
   input logic             busy_o,
   input logic             done_o,
   input logic [15:0]      crc_o
);

   // R4
   stall_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid_i && in_ready_o && !start_i) |=> !in_ready_o);

   // R5
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !start_i) |=> !done_o);

   // R5
   result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !start_i) |=> $stable(crc_o));

   // R3
   start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (crc_o == 16'h0000));

   // R3
   start_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !(USE_COUNT && count_i == '0)) |=> in_ready_o);

   // R8
   zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (USE_COUNT && start_i && count_i == '0) |=> (done_o && !busy_o && crc_o == 16'h0000));

   // R9
   idle_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !in_ready_o);

endmodule

bind cfgrom_crc16 crc16_chk #(
   .CNT_W     (CNT_W),
   .USE_COUNT (USE_COUNT)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start_i    (start_i),
   .count_i    (count_i),
   .in_valid_i (in_valid_i),
   .in_ready_o (in_ready_o),
   .busy_o     (busy_o),
   .done_o     (done_o),
   .crc_o      (crc_o)
);

// File: tb/tb_cfgrom_crc16.sv
`timescale 1ns/1ps
module tb_cfgrom_crc16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [15:0] count = '0;
   logic        valid = 1'b0;
   logic [31:0] data = '0;
   logic        last = 1'b0;

   logic        rdy_c, busy_c, done_c;
   logic [15:0] crc_c;
   logic        rdy_f, busy_f, done_f;
   logic [15:0] crc_f;

   int n_chk  = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   cfgrom_crc16 #(.USE_COUNT(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .start_i(start), .count_i(count),
      .in_valid_i(valid), .in_ready_o(rdy_c), .in_data_i(data), .in_last_i(last),
      .busy_o(busy_c), .done_o(done_c), .crc_o(crc_c));

   cfgrom_crc16 #(.USE_COUNT(1'b0)) dut_flag (
      .clk(clk), .rst_n(rst_n), .start_i(start), .count_i(count),
      .in_valid_i(valid), .in_ready_o(rdy_f), .in_data_i(data), .in_last_i(last),
      .busy_o(busy_f), .done_o(done_f), .crc_o(crc_f));

   localparam logic [31:0] QUADS [16] = '{
      32'h00000001, 32'h00000000, 32'hDEADBEEF, 32'h12345678,
      32'hFFFFFFFF, 32'h80000000, 32'h0000FFFF, 32'hA5A5A5A5,
      32'h3F1003F1, 32'hCAFEF00D, 32'h00010203, 32'h7FFFFFFE,
      32'h55AA55AA, 32'h0F0F0F0F, 32'hFEDCBA98, 32'h13579BDF};

   // {first index, quadlet count}
   localparam int CASES [7][2] = '{
      '{0, 1}, '{1, 1}, '{2, 3}, '{4, 5}, '{0, 16}, '{9, 2}, '{3, 0}};

   function automatic logic [15:0] ref_crc(input int first, input int n);
      logic [15:0] c = 16'h0000;
      for (int q = 0; q < n; q++) begin
         for (int sh = 28; sh >= 0; sh -= 4) begin
            logic [3:0] fb;
            fb = c[15:12] ^ 4'(QUADS[first+q] >> sh);
            c  = (c << 4) ^ (16'(fb) << 12) ^ (16'(fb) << 5) ^ 16'(fb);
         end
      end
      return c;
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic pulse_start(input int n);
      start = 1'b1;
      count = 16'(n);
      @(negedge clk);
      start = 1'b0;
   endtask

   // Offer one quadlet and check the eight-cycle fold window and its outcome.
   task automatic send_check(input logic [31:0] d, input bit lst,
                             input bit exp_dc, input bit exp_df,
                             input logic [15:0] exp_c, input logic [15:0] exp_f,
                             input string req_c, input string req_f);
      int guard = 0;
      while (!(rdy_c || rdy_f) && guard < 50) begin
         @(negedge clk);
         guard++;
      end
      valid = 1'b1;
      data  = d;
      last  = lst;
      @(negedge clk);
      valid = 1'b0;
      last  = 1'b0;
      chk(!rdy_c && !rdy_f, "R4", "ready during fold", {30'd0, rdy_c, rdy_f}, 32'd0);
      repeat (7) @(negedge clk);
      chk(!done_c && !done_f, "R5", "done before eighth step", {30'd0, done_c, done_f}, 32'd0);
      @(negedge clk);
      chk(done_c == exp_dc, req_c, "count-mode done", {31'd0, done_c}, {31'd0, exp_dc});
      chk(done_f == exp_df, req_f, "flag-mode done", {31'd0, done_f}, {31'd0, exp_df});
      if (exp_dc) chk(crc_c == exp_c, "R1", "count-mode result", {16'd0, crc_c}, {16'd0, exp_c});
      if (exp_df) chk(crc_f == exp_f, "R1", "flag-mode result", {16'd0, crc_f}, {16'd0, exp_f});
   endtask

   task automatic run_case(input int first, input int n, input int last_at);
      logic [15:0] ec, ef;
      pulse_start(n);
      chk(crc_c == 16'h0 && crc_f == 16'h0, "R3", "cleared after start", {crc_c, crc_f}, 32'd0);
      if (n == 0) begin
         chk(done_c && crc_c == 16'h0 && !rdy_c, "R8", "zero-count completion",
             {15'd0, done_c, crc_c}, 32'h0001_0000);
         @(negedge clk);
         chk(!done_c, "R5", "zero-count done width", {31'd0, done_c}, 32'd0);
         return;
      end
      chk(rdy_c, "R3", "ready after start", {31'd0, rdy_c}, 32'd1);
      ec = ref_crc(first, n);
      ef = ref_crc(first, last_at + 1);
      for (int i = 0; i < n; i++) begin
         send_check(QUADS[first+i], (i == last_at), (i == n - 1), (i == last_at),
                    ec, ef, "R6", "R7");
      end
      @(negedge clk);
      chk(!done_c && crc_c == ec, "R5", "done width and result hold",
          {15'd0, done_c, crc_c}, {16'd0, ec});
      chk(crc_f == ef, "R9", "flag-mode result after extra quadlets", {16'd0, crc_f}, {16'd0, ef});
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog run did not finish actual=hung expected=finish");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R2 reset state
      chk(crc_c == 0 && !done_c && !busy_c && !rdy_c, "R2", "count-mode reset",
          {13'd0, done_c, busy_c, rdy_c, crc_c}, 32'd0);
      chk(crc_f == 0 && !done_f && !busy_f && !rdy_f, "R2", "flag-mode reset",
          {13'd0, done_f, busy_f, rdy_f, crc_f}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // vector table walk
      for (int k = 0; k < 7; k++) begin
         run_case(CASES[k][0], CASES[k][1], CASES[k][1] - 1);
         if (k == 0) chk(crc_c == 16'h1021, "R10", "known single quadlet", {16'd0, crc_c}, 32'h1021);
         if (k == 1) chk(crc_c == 16'h0000, "R10", "all-zero quadlet", {16'd0, crc_c}, 32'h0);
      end

      // early last flag: flag mode ends after quadlet 0, count mode runs on (R6, R7)
      run_case(4, 3, 0);

      // R9 valid while idle has no effect
      begin
         logic [15:0] hc, hf;
         hc = crc_c;
         hf = crc_f;
         valid = 1'b1;
         data  = 32'hFFFF0000;
         last  = 1'b1;
         repeat (5) @(negedge clk);
         valid = 1'b0;
         last  = 1'b0;
         @(negedge clk);
         chk(crc_c == hc && crc_f == hf && !done_c && !done_f && !rdy_c && !rdy_f,
             "R9", "idle valid ignored", {crc_c, crc_f}, {hc, hf});
      end

      // R3 restart in the middle of a fold
      pulse_start(2);
      valid = 1'b1;
      data  = QUADS[7];
      @(negedge clk);
      valid = 1'b0;
      repeat (3) @(negedge clk);
      pulse_start(1);
      chk(crc_c == 0 && crc_f == 0 && rdy_c && rdy_f, "R3", "restart clears and reopens",
          {14'd0, rdy_c, rdy_f, crc_c | crc_f}, 32'h0003_0000);
      send_check(QUADS[5], 1'b1, 1'b1, 1'b1, ref_crc(5, 1), ref_crc(5, 1), "R3", "R3");

      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule